// File: doc/BRIEF.md
# LCD Panel Timing Generator with Line Inversion

This block produces the row timing for a passive-matrix LCD driver. As master it divides its input clock into a line latch clock, steps a display-RAM line address once per line and raises a frame sync pulse on the first line of every frame. It also generates an AC-drive polarity signal and passes its input clock out as the display clock. The polarity flips once per frame, or, when the n-line inversion mode is enabled, after every group of `nline_val_i + 1` lines counted from the start of the frame.

In a multi-chip panel one device is strapped as master and drives its pulse pins. The others are strapped as slaves. A slave stops its own generator, releases its pulse pins and samples the pulses the master sends. It steps its local line address on each falling edge of the received line clock, returns to line 0 on a rising edge of the received frame sync, and takes its polarity from the received polarity pin. In a slave the local `clk_i` is wired to the master's display clock output.

Top module: `lcd_timing_gen`

## Requirements
- R1: With `master_i` high, `pin_oe_o` is high and each line lasts DIV clocks. `cl_o` is high for the last DIV/2 clocks of a line and low for the rest. `latch_o` is a one-clock pulse in the last clock of each line, and `cl_o` is low in the clock after it.
- R2: In master mode `line_addr_o` changes only on the clock edge that ends a `latch_o` cycle. It then goes from L to L+1, and from LINES-1 to 0.
- R3: In master mode `flm_o` is high exactly while `line_addr_o` is 0, which is one line per frame.
- R4: With `nline_en_i` low, `fr_o` inverts only when the line address goes from LINES-1 to 0. It holds at every other line step and in every clock without `latch_o`.
- R5: With `nline_en_i` high and `nline_val_i` = v, `fr_o` inverts when the line address steps to a new line k exactly when k is not 0 and k is a multiple of v+1. There is no inversion at the frame wrap, and the group count restarts there.
- R6: While `rst_ni` is low, `line_addr_o` is 0, `fr_o` is 0, `cl_o` is 0 and `latch_o` is 0.
- R7: With `master_i` low, `pin_oe_o`, `cl_o`, `flm_o`, `fr_o` and `dclk_o` are all 0 whatever the received pins do.
- R8: In slave mode `line_addr_o` steps by one, wrapping from LINES-1 to 0, a few clocks after each falling edge of `cl_i`. Only such an edge or a received frame sync moves it.
- R9: In slave mode a rising edge of `flm_i` sets `line_addr_o` to 0. This holds even when it arrives in the same clock as a falling edge of `cl_i`.
- R10: `pol_o` equals `fr_o` in master mode. In slave mode it follows `fr_i` after the input synchronizer delay.
- R11: `dclk_o` equals `clk_i` in master mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock (master) or received display clock (slave) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_i | input | 1 | Mode strap: 1 master, 0 slave |
| nline_en_i | input | 1 | 1 selects n-line polarity inversion, 0 per-frame inversion |
| nline_val_i | input | INV_W | Inversion group length minus one |
| cl_i | input | 1 | Received line latch clock (slave) |
| flm_i | input | 1 | Received frame sync (slave) |
| fr_i | input | 1 | Received polarity (slave) |
| pin_oe_o | output | 1 | Drive enable for the four pulse pins |
| cl_o | output | 1 | Line latch clock drive value |
| flm_o | output | 1 | Frame sync drive value |
| fr_o | output | 1 | Polarity drive value |
| dclk_o | output | 1 | Display clock drive value |
| line_addr_o | output | LW | Display-RAM line address |
| latch_o | output | 1 | One-clock strobe per line for the segment data latch |
| pol_o | output | 1 | Polarity used by the local drive stages |

## Verification
The hardest cases are two. One is a slave receiving the frame sync edge in the same clock as a line clock fall. The other is n-line inversion at a frame end where the lines do not divide evenly into groups. For the first, the bench changes `cl_i` and `flm_i` on the same clock so that both edges leave the synchronizer together, and then expects line 0 rather than the next line. For the second, the bench runs full frames of 82 lines with groups of 4, so a two-line remainder meets the wrap. It also runs groups of 1 and groups longer than a frame, and it predicts each inversion from the position of the line alone.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  // Bundle of the three received timing pins.
  typedef struct packed {
    logic cl;
    logic flm;
    logic fr;
  } pulse_t;

endpackage

// File: rtl/lcd_tg_rst_sync.sv
module lcd_tg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_no = sh_q[STAGES-1];

endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic cl_o,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST    = CW'(DIV - 1);
  localparam logic [CW-1:0] HI_FROM = CW'(DIV - DIV / 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == LAST);
  assign cl_o   = run_i && (cnt_q >= HI_FROM);

endmodule

// File: rtl/lcd_tg_pin_sync.sv
module lcd_tg_pin_sync
  import lcd_tg_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  pulse_t pins_i,
  output logic   cl_fall_o,
  output logic   flm_rise_o,
  output logic   fr_o
);

  pulse_t stg_q [STAGES];
  pulse_t stg_d [STAGES];
  logic   cl_prev_q, cl_prev_d;
  logic   flm_prev_q, flm_prev_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stg_d[i] = pins_i;
    end else begin : g_next
      assign stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_d[i];
    end
  end

  always_comb begin
    cl_prev_d  = stg_q[STAGES-1].cl;
    flm_prev_d = stg_q[STAGES-1].flm;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_prev_q  <= 1'b0;
      flm_prev_q <= 1'b0;
    end else begin
      cl_prev_q  <= cl_prev_d;
      flm_prev_q <= flm_prev_d;
    end
  end

  assign cl_fall_o  = cl_prev_q && !stg_q[STAGES-1].cl;
  assign flm_rise_o = !flm_prev_q && stg_q[STAGES-1].flm;
  assign fr_o       = stg_q[STAGES-1].fr;

endmodule

// File: rtl/lcd_tg_linectr.sv
module lcd_tg_linectr #(
  parameter int unsigned LINES = 82,
  parameter int unsigned LW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          m_tick_i,
  input  logic          s_step_i,
  input  logic          s_zero_i,
  output logic [LW-1:0] line_o,
  output logic          wrap_o
);

  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  logic [LW-1:0] line_q;
  logic [LW-1:0] line_d;
  logic [LW-1:0] line_inc;

  always_comb begin
    line_inc = (line_q == LAST) ? '0 : line_q + 1'b1;
    line_d   = line_q;
    if (master_i) begin
      if (m_tick_i) line_d = line_inc;
    end else begin
      if (s_zero_i)      line_d = '0;
      else if (s_step_i) line_d = line_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d;
  end

  assign line_o = line_q;
  assign wrap_o = master_i && m_tick_i && (line_q == LAST);

endmodule

// File: rtl/lcd_tg_polarity.sv
module lcd_tg_polarity #(
  parameter int unsigned INV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic             nline_en_i,
  input  logic [INV_W-1:0] nline_val_i,
  output logic             fr_o
);

  logic [INV_W-1:0] grp_q, grp_d;
  logic             fr_q, fr_d;

  always_comb begin
    grp_d = grp_q;
    fr_d  = fr_q;
    if (run_i && tick_i) begin
      if (wrap_i) begin
        grp_d = '0;
        if (!nline_en_i) fr_d = !fr_q;
      end else if (nline_en_i) begin
        if (grp_q >= nline_val_i) begin
          grp_d = '0;
          fr_d  = !fr_q;
        end else begin
          grp_d = grp_q + 1'b1;
        end
      end else begin
        grp_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      fr_q  <= 1'b0;
    end else begin
      grp_q <= grp_d;
      fr_q  <= fr_d;
    end
  end

  assign fr_o = fr_q;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter  int unsigned DIV         = 8,
  parameter  int unsigned LINES       = 82,
  parameter  int unsigned INV_W       = 7,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned LW          = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic             nline_en_i,
  input  logic [INV_W-1:0] nline_val_i,
  input  logic             cl_i,
  input  logic             flm_i,
  input  logic             fr_i,
  output logic             pin_oe_o,
  output logic             cl_o,
  output logic             flm_o,
  output logic             fr_o,
  output logic             dclk_o,
  output logic [LW-1:0]    line_addr_o,
  output logic             latch_o,
  output logic             pol_o
);

  logic          rst_n;
  logic          div_cl;
  logic          div_tick;
  logic          s_cl_fall;
  logic          s_flm_rise;
  logic          s_fr;
  logic [LW-1:0] line;
  logic          wrap;
  logic          fr_q;
  pulse_t        rx_pins;

  assign rx_pins = '{cl: cl_i, flm: flm_i, fr: fr_i};

  lcd_tg_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  lcd_tg_clkdiv #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .run_i (master_i),
    .cl_o  (div_cl),
    .tick_o(div_tick)
  );

  lcd_tg_pin_sync #(.STAGES(SYNC_STAGES)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .pins_i    (rx_pins),
    .cl_fall_o (s_cl_fall),
    .flm_rise_o(s_flm_rise),
    .fr_o      (s_fr)
  );

  lcd_tg_linectr #(.LINES(LINES), .LW(LW)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .master_i(master_i),
    .m_tick_i(div_tick),
    .s_step_i(s_cl_fall),
    .s_zero_i(s_flm_rise),
    .line_o  (line),
    .wrap_o  (wrap)
  );

  lcd_tg_polarity #(.INV_W(INV_W)) u_pol (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (master_i),
    .tick_i     (div_tick),
    .wrap_i     (wrap),
    .nline_en_i (nline_en_i),
    .nline_val_i(nline_val_i),
    .fr_o       (fr_q)
  );

  assign pin_oe_o    = master_i;
  assign cl_o        = master_i && div_cl;
  assign flm_o       = master_i && (line == '0);
  assign fr_o        = master_i && fr_q;
  assign dclk_o      = master_i && clk_i;
  assign line_addr_o = line;
  assign latch_o     = master_i ? div_tick : (s_cl_fall || s_flm_rise);
  assign pol_o       = master_i ? fr_q : s_fr;

endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker #(
  parameter int unsigned LINES = 82,
  parameter int unsigned LW    = 7
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic          master_i,
  input logic          nline_en_i,
  input logic          pin_oe_o,
  input logic          cl_o,
  input logic          flm_o,
  input logic          fr_o,
  input logic          latch_o,
  input logic [LW-1:0] line_addr_o
);

  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  p_cl_low_after_latch_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    master_i && latch_o |=> !cl_o);

  p_line_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    master_i && latch_o && (line_addr_o != LAST) |=> line_addr_o == $past(line_addr_o) + 1'b1);

  p_line_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    master_i && latch_o && (line_addr_o == LAST) |=> line_addr_o == '0);

  p_flm_after_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    master_i && $rose(flm_o) |-> $past(latch_o));

  p_fr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    master_i && !latch_o |=> $stable(fr_o));

  p_fr_no_wrap_flip_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    master_i && nline_en_i && latch_o && (line_addr_o == LAST) |=> $stable(fr_o));

  p_slave_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !master_i |-> !pin_oe_o && !cl_o && !flm_o && !fr_o);

  p_slave_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !master_i && !latch_o |=> $stable(line_addr_o));

endmodule

bind lcd_timing_gen lcd_tg_checker #(.LINES(LINES), .LW(LW)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .master_i   (master_i),
  .nline_en_i (nline_en_i),
  .pin_oe_o   (pin_oe_o),
  .cl_o       (cl_o),
  .flm_o      (flm_o),
  .fr_o       (fr_o),
  .latch_o    (latch_o),
  .line_addr_o(line_addr_o)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;

  localparam int unsigned DIV   = 8;
  localparam int unsigned LINES = 82;
  localparam int unsigned INV_W = 7;
  localparam int unsigned LW    = $clog2(LINES);

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             master_i;
  logic             nline_en_i;
  logic [INV_W-1:0] nline_val_i;
  logic             cl_i, flm_i, fr_i;
  logic             pin_oe_o, cl_o, flm_o, fr_o, dclk_o, latch_o, pol_o;
  logic [LW-1:0]    line_addr_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  lcd_timing_gen #(.DIV(DIV), .LINES(LINES), .INV_W(INV_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .nline_en_i(nline_en_i),
    .nline_val_i(nline_val_i), .cl_i(cl_i), .flm_i(flm_i), .fr_i(fr_i),
    .pin_oe_o(pin_oe_o), .cl_o(cl_o), .flm_o(flm_o), .fr_o(fr_o), .dclk_o(dclk_o),
    .line_addr_o(line_addr_o), .latch_o(latch_o), .pol_o(pol_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit mst, input bit en, input int v);
    @(negedge clk);
    rst_ni      = 1'b0;
    master_i    = mst;
    nline_en_i  = en;
    nline_val_i = INV_W'(v);
    cl_i = 1'b0; flm_i = 1'b0; fr_i = 1'b0;
    repeat (3) @(negedge clk);
    // R6: state held in reset
    chk(line_addr_o == '0, "R6 line_addr", int'(line_addr_o), 0);
    chk(fr_o == 1'b0, "R6 fr_o", int'(fr_o), 0);
    chk(cl_o == 1'b0 && latch_o == 1'b0, "R6 cl_o/latch_o", int'({cl_o, latch_o}), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_latch();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!latch_o && guard < 4 * DIV);
  endtask

  // R1: line length, CL duty and latch placement
  task automatic t_cl_shape();
    chk(pin_oe_o == 1'b1, "R1 pin_oe_o", int'(pin_oe_o), 1);
    wait_latch();
    for (int n = 0; n < 3; n++) begin
      int cyc = 0;
      int hi  = 0;
      @(negedge clk);
      cyc++;
      chk(cl_o == 1'b0, "R1 cl_o after latch", int'(cl_o), 0);
      if (cl_o) hi++;
      while (!latch_o && cyc < 4 * DIV) begin
        @(negedge clk);
        cyc++;
        if (cl_o) hi++;
      end
      chk(cyc == DIV, "R1 line length", cyc, DIV);
      chk(hi == DIV / 2, "R1 cl_o high clocks", hi, DIV / 2);
    end
  endtask

  // R2, R3, R4/R5 (tag given), R10: walk lines and predict every step
  task automatic run_lines(input int nlines, input bit en, input int v, input string frtag);
    int flm_err = 0;
    int hold_err = 0;
    int pol_err = 0;
    int flips = 0;
    int exp_flips = 0;
    wait_latch();
    for (int n = 0; n < nlines; n++) begin
      int l_now = int'(line_addr_o);
      int k = (l_now + 1) % LINES;
      bit f_now = fr_o;
      bit tog = en ? (k != 0 && (k % (v + 1)) == 0) : (k == 0);
      @(negedge clk);
      chk(int'(line_addr_o) == k, "R2 line step", int'(line_addr_o), k);
      if (fr_o != (f_now ^ tog)) begin
        chk(1'b0, frtag, int'(fr_o), int'(f_now ^ tog));
      end else begin
        total++;
      end
      if (tog) exp_flips++;
      if (fr_o != f_now) flips++;
      while (!latch_o) begin
        bit f_hold = fr_o;
        if (flm_o != (line_addr_o == '0)) flm_err++;
        if (pol_o != fr_o) pol_err++;
        @(negedge clk);
        if (fr_o != f_hold) hold_err++;
      end
    end
    chk(flm_err == 0, "R3 flm_o vs line 0", flm_err, 0);
    chk(hold_err == 0, frtag, hold_err, 0);
    chk(pol_err == 0, "R10 pol_o master", pol_err, 0);
    chk(flips == exp_flips, frtag, flips, exp_flips);
  endtask

  // R11: display clock pass-through
  task automatic t_dclk(input bit mst);
    @(posedge clk);
    #1;
    chk(dclk_o == mst, "R11 dclk_o high phase", int'(dclk_o), int'(mst));
    @(negedge clk);
    #1;
    chk(dclk_o == 1'b0, "R11 dclk_o low phase", int'(dclk_o), 0);
  endtask

  task automatic s_line();
    cl_i = 1'b1;
    repeat (4) @(negedge clk);
    cl_i = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // R7, R8, R9, R10 slave behaviour
  task automatic t_slave();
    int quiet_err = 0;
    do_reset(1'b0, 1'b0, 0);
    for (int n = 0; n < 5; n++) begin
      s_line();
      if (pin_oe_o || cl_o || flm_o || fr_o || dclk_o) quiet_err++;
    end
    chk(int'(line_addr_o) == 5, "R8 slave count", int'(line_addr_o), 5);
    chk(quiet_err == 0, "R7 slave pins quiet", quiet_err, 0);
    flm_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(line_addr_o == '0, "R9 flm resync", int'(line_addr_o), 0);
    flm_i = 1'b0;
    repeat (4) @(negedge clk);
    for (int n = 0; n < 3; n++) s_line();
    chk(int'(line_addr_o) == 3, "R8 slave count after resync", int'(line_addr_o), 3);
    cl_i = 1'b1;
    repeat (4) @(negedge clk);
    cl_i  = 1'b0;
    flm_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(line_addr_o == '0, "R9 flm beats cl fall", int'(line_addr_o), 0);
    flm_i = 1'b0;
    repeat (4) @(negedge clk);
    for (int n = 0; n < LINES - 1; n++) s_line();
    chk(int'(line_addr_o) == LINES - 1, "R8 slave last line", int'(line_addr_o), LINES - 1);
    s_line();
    chk(line_addr_o == '0, "R8 slave wrap", int'(line_addr_o), 0);
    fr_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(pol_o == 1'b1, "R10 pol_o follows fr_i", int'(pol_o), 1);
    chk(fr_o == 1'b0 && pin_oe_o == 1'b0, "R7 fr_o/pin_oe_o slave", int'({fr_o, pin_oe_o}), 0);
    fr_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(pol_o == 1'b0, "R10 pol_o follows fr_i low", int'(pol_o), 0);
    t_dclk(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    master_i = 1'b1; nline_en_i = 1'b0; nline_val_i = '0;
    cl_i = 1'b0; flm_i = 1'b0; fr_i = 1'b0;
    do_reset(1'b1, 1'b0, 0);
    t_cl_shape();
    t_dclk(1'b1);
    run_lines(2 * LINES + 10, 1'b0, 0, "R4 frame polarity");
    do_reset(1'b1, 1'b1, 3);
    run_lines(2 * LINES + 4, 1'b1, 3, "R5 groups of 4");
    do_reset(1'b1, 1'b1, 0);
    run_lines(LINES + 3, 1'b1, 0, "R5 groups of 1");
    do_reset(1'b1, 1'b1, 100);
    run_lines(LINES + 3, 1'b1, 100, "R5 group longer than frame");
    t_slave();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule